// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes the architectural state change a 32-bit RISC core makes when it accepts an exception. Each cycle it takes the current program counter, the current status word and a vector of pending exception requests. It drops any interrupt request that the status word currently disables, selects one winner by fixed priority, and returns combinationally four values: the return link, the status word to save, the status word for the handler, and the handler's fetch address.

The block also holds one link register and one saved-status register for each privileged mode. These are written on the clock edge in the cycle an exception is accepted. A read port selected by a bank index lets the core, or a bench, look at any bank. The core places the returned program counter and status word into its own state. Instruction decode and the general register file belong to the core, not to this block.

Top module: `exc_entry_seq`

## Requirements
- R1: Request bit mapping is `req[0]` reset, `req[1]` undefined instruction, `req[2]` software interrupt, `req[3]` prefetch abort, `req[4]` data abort, `req[5]` IRQ, `req[6]` FIQ. When several unmasked requests are pending, the winner is chosen in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R2: `exc_new_pc` is `VEC_BASE` plus a fixed offset per exception: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The offset 0x14 is never produced.
- R3: On an accepted exception, `exc_link` equals `cur_pc + 4` modulo 2^32, and `exc_saved_psr` equals `cur_psr`.
- R4: `exc_new_psr[4:0]` carries the entered mode: FIQ 10001, IRQ 10010, supervisor 10011 (reset and software interrupt), abort 10111 (both aborts), undefined 11011.
- R5: On entry, `exc_new_psr[5]` is 0, `exc_new_psr[7]` is 1, and `exc_new_psr[31:8]` equals `cur_psr[31:8]`.
- R6: `exc_new_psr[6]` is set to 1 for reset and FIQ. For every other exception it keeps the value of `cur_psr[6]`.
- R7: `req[5]` is ignored while `cur_psr[7]` is 1, and `req[6]` is ignored while `cur_psr[6]` is 1. A masked request may not win, and it lets a lower-priority request win.
- R8: With no accepted request, `exc_taken` is 0, `exc_new_pc` equals `cur_pc`, `exc_new_psr` equals `cur_psr`, and no bank changes.
- R9: On the clock edge of an accepted exception, the bank of the entered mode stores `exc_link` and `exc_saved_psr`. `rd_bank` selects the bank to read: 0 FIQ, 1 IRQ, 2 supervisor, 3 abort, 4 undefined. Any other index, including user mode, reads zero.
- R10: A synchronous active-low reset clears every bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | Current program counter |
| cur_psr | input | 32 | Current status word |
| req | input | 7 | Pending exception requests, one bit per kind |
| rd_bank | input | 3 | Bank select for the read port |
| exc_taken | output | 1 | An exception is accepted this cycle |
| exc_link | output | 32 | Return link for the entered mode |
| exc_saved_psr | output | 32 | Status word to save for the entered mode |
| exc_new_psr | output | 32 | Status word for the handler |
| exc_new_pc | output | 32 | Handler fetch address |
| rd_link | output | 32 | Stored link of the selected bank |
| rd_saved_psr | output | 32 | Stored saved status of the selected bank |

## Verification
The bench aims at cases where masking and priority interact:
- An FIQ disabled by the status word while an IRQ is also pending should let the IRQ win. A design that skips the mask would vector to 0x1C.
- All requests raised at once must give reset.
- Undefined and software interrupt raised together must give undefined.

It checks that bit 6 is kept from the old status word for non-FIQ entries; a design that cleared or forced the bit would fail there. A program counter of 0xFFFFFFFC checks that the link wraps to zero. Entries that share a bank, such as reset after a software interrupt, check that the later entry overwrites the stored link, and out-of-range bank indices must read zero.

// File: rtl/exc_pkg.sv
// Shared types and encodings for the exception entry sequencer.
// Assumes a status word of at least 8 bits, with mode in [4:0].
package exc_pkg;

    localparam int NREQ  = 7;
    localparam int NBANK = 5;
    localparam int BKW   = 3;

    typedef enum logic [2:0] {
        EX_RST  = 3'd0,
        EX_UND  = 3'd1,
        EX_SWI  = 3'd2,
        EX_PAB  = 3'd3,
        EX_DAB  = 3'd4,
        EX_IRQ  = 3'd5,
        EX_FIQ  = 3'd6,
        EX_NONE = 3'd7
    } exc_kind_e;

    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;

    localparam logic [BKW-1:0] BK_FIQ = 3'd0;
    localparam logic [BKW-1:0] BK_IRQ = 3'd1;
    localparam logic [BKW-1:0] BK_SVC = 3'd2;
    localparam logic [BKW-1:0] BK_ABT = 3'd3;
    localparam logic [BKW-1:0] BK_UND = 3'd4;

    // Mode number entered by each exception kind.
    function automatic logic [4:0] mode_of(exc_kind_e k);
        case (k)
            EX_FIQ:         return MODE_FIQ;
            EX_IRQ:         return MODE_IRQ;
            EX_PAB, EX_DAB: return MODE_ABT;
            EX_UND:         return MODE_UND;
            default:        return MODE_SVC;
        endcase
    endfunction

    // Vector offset of each exception kind (0x14 is never used).
    function automatic logic [7:0] vec_of(exc_kind_e k);
        case (k)
            EX_RST:  return 8'h00;
            EX_UND:  return 8'h04;
            EX_SWI:  return 8'h08;
            EX_PAB:  return 8'h0C;
            EX_DAB:  return 8'h10;
            EX_IRQ:  return 8'h18;
            EX_FIQ:  return 8'h1C;
            default: return 8'h00;
        endcase
    endfunction

    // Bank index that holds link and saved status for the entered mode.
    function automatic logic [BKW-1:0] bank_of(exc_kind_e k);
        case (k)
            EX_FIQ:         return BK_FIQ;
            EX_IRQ:         return BK_IRQ;
            EX_PAB, EX_DAB: return BK_ABT;
            EX_UND:         return BK_UND;
            default:        return BK_SVC;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
// Masks the interrupt requests with the disable bits of the status word,
// then selects one winner by fixed priority.
// Assumes request bit i encodes exc_kind_e value i.
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  logic            irq_off,
    input  logic            fiq_off,
    output exc_kind_e       kind,
    output logic            taken
);

    logic [NREQ-1:0] live;

    // Drop the interrupt lines that the status word disables.
    always_comb begin
        live         = req;
        live[EX_IRQ] = req[EX_IRQ] & ~irq_off;
        live[EX_FIQ] = req[EX_FIQ] & ~fiq_off;
    end

    // Fixed priority: reset, dabort, fiq, irq, pabort, undef, swi.
    always_comb begin
        if      (live[EX_RST]) kind = EX_RST;
        else if (live[EX_DAB]) kind = EX_DAB;
        else if (live[EX_FIQ]) kind = EX_FIQ;
        else if (live[EX_IRQ]) kind = EX_IRQ;
        else if (live[EX_PAB]) kind = EX_PAB;
        else if (live[EX_UND]) kind = EX_UND;
        else if (live[EX_SWI]) kind = EX_SWI;
        else                   kind = EX_NONE;
    end

    // Flag an accepted exception.
    always_comb taken = (kind != EX_NONE);

endmodule

// File: rtl/exc_state_gen.sv
// Builds the return link, saved status, handler status and handler address
// for the selected exception kind. When no kind is selected, the current
// program counter and status word pass through unchanged.
// Assumes XLEN >= 8.
module exc_state_gen
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] LINK_OFS = 4,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  exc_kind_e       kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_psr,
    output logic [XLEN-1:0] link,
    output logic [XLEN-1:0] saved_psr,
    output logic [XLEN-1:0] new_psr,
    output logic [XLEN-1:0] new_pc
);

    localparam int PADW = XLEN - 8;

    // Return link and status copy.
    always_comb begin
        link      = cur_pc + LINK_OFS;
        saved_psr = cur_psr;
    end

    // Handler status word: mode, state bit cleared, interrupt disables.
    always_comb begin
        new_psr = cur_psr;
        if (kind != EX_NONE) begin
            new_psr[4:0] = mode_of(kind);
            new_psr[5]   = 1'b0;
            new_psr[7]   = 1'b1;
            if (kind == EX_RST || kind == EX_FIQ) begin
                new_psr[6] = 1'b1;
            end
        end
    end

    // Handler fetch address.
    always_comb begin
        if (kind != EX_NONE) new_pc = VEC_BASE + {{PADW{1'b0}}, vec_of(kind)};
        else                 new_pc = cur_pc;
    end

endmodule

// File: rtl/exc_bank_regs.sv
// Link and saved-status storage, one pair per privileged mode, with a
// single write port and a combinational read port. Out-of-range indices
// read zero.
// Assumes NBANK fits in the bank index width.
module exc_bank_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BKW-1:0]  wr_bank,
    input  logic [XLEN-1:0] wr_link,
    input  logic [XLEN-1:0] wr_psr,
    input  logic [BKW-1:0]  rd_bank,
    output logic [XLEN-1:0] rd_link,
    output logic [XLEN-1:0] rd_psr
);

    logic [XLEN-1:0] link_arr [NBANK];
    logic [XLEN-1:0] psr_arr  [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [XLEN-1:0] lk_q;
        logic [XLEN-1:0] ps_q;

        // Capture link and status when this bank is the target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_q <= '0;
                ps_q <= '0;
            end else if (wr_en && wr_bank == BKW'(b)) begin
                lk_q <= wr_link;
                ps_q <= wr_psr;
            end
        end

        assign link_arr[b] = lk_q;
        assign psr_arr[b]  = ps_q;
    end

    // Read mux; indices past the last bank return zero.
    always_comb begin
        rd_link = '0;
        rd_psr  = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (rd_bank == BKW'(i)) begin
                rd_link = link_arr[i];
                rd_psr  = psr_arr[i];
            end
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Top of the exception entry sequencer: arbitration, state generation and
// banked storage. The computed outputs are combinational from the inputs;
// banks update on the clock edge of an accepted exception.
// Assumes a synchronous active-low reset.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] LINK_OFS = 4,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_psr,
    input  logic [NREQ-1:0] req,
    input  logic [BKW-1:0]  rd_bank,
    output logic            exc_taken,
    output logic [XLEN-1:0] exc_link,
    output logic [XLEN-1:0] exc_saved_psr,
    output logic [XLEN-1:0] exc_new_psr,
    output logic [XLEN-1:0] exc_new_pc,
    output logic [XLEN-1:0] rd_link,
    output logic [XLEN-1:0] rd_saved_psr
);

    exc_kind_e      kind;
    logic [BKW-1:0] tgt_bank;

    exc_prio_arb u_arb (
        .req     (req),
        .irq_off (cur_psr[7]),
        .fiq_off (cur_psr[6]),
        .kind    (kind),
        .taken   (exc_taken)
    );

    exc_state_gen #(
        .XLEN     (XLEN),
        .LINK_OFS (LINK_OFS),
        .VEC_BASE (VEC_BASE)
    ) u_gen (
        .kind      (kind),
        .cur_pc    (cur_pc),
        .cur_psr   (cur_psr),
        .link      (exc_link),
        .saved_psr (exc_saved_psr),
        .new_psr   (exc_new_psr),
        .new_pc    (exc_new_pc)
    );

    // Bank written by the entered mode.
    always_comb tgt_bank = bank_of(kind);

    exc_bank_regs #(
        .XLEN (XLEN)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (exc_taken),
        .wr_bank (tgt_bank),
        .wr_link (exc_link),
        .wr_psr  (exc_saved_psr),
        .rd_bank (rd_bank),
        .rd_link (rd_link),
        .rd_psr  (rd_saved_psr)
    );

endmodule

// File: rtl/exc_entry_seq_chk.sv
// Property checker for the exception entry sequencer, bound to the top.
module exc_entry_seq_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] LINK_OFS = 4,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] cur_psr,
    input logic [6:0]      req,
    input logic [2:0]      rd_bank,
    input logic            exc_taken,
    input logic [XLEN-1:0] exc_link,
    input logic [XLEN-1:0] exc_saved_psr,
    input logic [XLEN-1:0] exc_new_psr,
    input logic [XLEN-1:0] exc_new_pc,
    input logic [XLEN-1:0] rd_link,
    input logic [XLEN-1:0] rd_saved_psr
);

    localparam logic [XLEN-1:0] VEC_RSV = VEC_BASE + XLEN'(32'h14);
    localparam logic [XLEN-1:0] VEC_RST = VEC_BASE;
    localparam logic [XLEN-1:0] VEC_FIQ = VEC_BASE + XLEN'(32'h1C);

    assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (exc_taken && exc_new_pc == VEC_RST && exc_new_psr[4:0] == 5'b10011));

    assert_no_reserved_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (exc_new_pc != VEC_RSV));

    assert_link_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (exc_link == cur_pc + LINK_OFS && exc_saved_psr == cur_psr));

    assert_psr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!exc_new_psr[5] && exc_new_psr[7] && exc_new_psr[XLEN-1:8] == cur_psr[XLEN-1:8]));

    assert_fiq_bit_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_new_pc != VEC_RST && exc_new_pc != VEC_FIQ) |-> (exc_new_psr[6] == cur_psr[6]));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req[5] && cur_psr[7] && !req[6] && req[4:0] == 5'b0) |-> !exc_taken);

    assert_idle_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |-> (exc_new_pc == cur_pc && exc_new_psr == cur_psr));

    assert_svc_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_new_psr[4:0] == 5'b10011) |=> (rd_bank != 3'd2 || rd_link == $past(exc_link)));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN     (XLEN),
    .LINK_OFS (LINK_OFS),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_pc        (cur_pc),
    .cur_psr       (cur_psr),
    .req           (req),
    .rd_bank       (rd_bank),
    .exc_taken     (exc_taken),
    .exc_link      (exc_link),
    .exc_saved_psr (exc_saved_psr),
    .exc_new_psr   (exc_new_psr),
    .exc_new_pc    (exc_new_pc),
    .rd_link       (rd_link),
    .rd_saved_psr  (rd_saved_psr)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psr = '0;
    logic [6:0]  req = '0;
    logic [2:0]  rd_bank = '0;
    logic        exc_taken;
    logic [31:0] exc_link, exc_saved_psr, exc_new_psr, exc_new_pc;
    logic [31:0] rd_link, rd_saved_psr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_link [5];
    logic [31:0] m_psr  [5];

    always #2 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_psr(cur_psr),
        .req(req), .rd_bank(rd_bank), .exc_taken(exc_taken),
        .exc_link(exc_link), .exc_saved_psr(exc_saved_psr),
        .exc_new_psr(exc_new_psr), .exc_new_pc(exc_new_pc),
        .rd_link(rd_link), .rd_saved_psr(rd_saved_psr)
    );

    // Winner index per R1/R7: 0 rst,1 und,2 swi,3 pab,4 dab,5 irq,6 fiq, 7 none.
    function automatic int pick(logic [6:0] r, logic [31:0] p);
        if (r[0]) return 0;
        if (r[4]) return 4;
        if (r[6] && !p[6]) return 6;
        if (r[5] && !p[7]) return 5;
        if (r[3]) return 3;
        if (r[1]) return 1;
        if (r[2]) return 2;
        return 7;
    endfunction

    function automatic logic [31:0] vec(int k);
        case (k)
            0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
            4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
        endcase
    endfunction

    function automatic logic [4:0] mode(int k);
        case (k)
            6: return 5'b10001; 5: return 5'b10010; 3, 4: return 5'b10111;
            1: return 5'b11011; default: return 5'b10011;
        endcase
    endfunction

    function automatic int bank(int k);
        case (k)
            6: return 0; 5: return 1; 3, 4: return 3; 1: return 4; default: return 2;
        endcase
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, check combinational outputs and bank read, update model.
    task automatic step(logic [6:0] r, logic [31:0] pc, logic [31:0] psr, logic [2:0] rb);
        int k;
        logic [31:0] e_psr;
        @(negedge clk);
        req = r; cur_pc = pc; cur_psr = psr; rd_bank = rb;
        #1;
        k = pick(r, psr);
        e_psr = psr;
        if (k != 7) begin
            e_psr[4:0] = mode(k);
            e_psr[5] = 1'b0;
            e_psr[7] = 1'b1;
            if (k == 0 || k == 6) e_psr[6] = 1'b1;
        end
        check32("R1 taken", {31'b0, exc_taken}, {31'b0, k != 7});
        if (k != 7) begin
            check32("R2 new_pc", exc_new_pc, vec(k));
            check32("R3 link", exc_link, pc + 32'd4);
            check32("R3 saved_psr", exc_saved_psr, psr);
            check32("R4 R5 R6 new_psr", exc_new_psr, e_psr);
        end else begin
            check32("R8 idle pc", exc_new_pc, pc);
            check32("R8 idle psr", exc_new_psr, psr);
        end
        check32("R9 rd_link", rd_link, (rb < 3'd5) ? m_link[rb] : 32'h0);
        check32("R9 rd_psr", rd_saved_psr, (rb < 3'd5) ? m_psr[rb] : 32'h0);
        @(posedge clk);
        if (k != 7) begin
            m_link[bank(k)] = pc + 32'd4;
            m_psr[bank(k)]  = psr;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 5; i++) begin m_link[i] = '0; m_psr[i] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: banks read zero after reset.
        for (int b = 0; b < 5; b++) step(7'h00, 32'h100, 32'h10, 3'(b));
        // R1 all raised: reset wins; T bit set in old status.
        step(7'h7F, 32'h0000_2000, 32'hF000_0030, 3'd2);
        // R1 undefined beats software interrupt.
        step(7'h06, 32'h0000_3000, 32'h0000_0010, 3'd4);
        // R7 FIQ masked, IRQ enabled: IRQ wins.
        step(7'h60, 32'h0000_4000, 32'h0000_0050, 3'd1);
        // R7 both masked with prefetch abort: abort wins.
        step(7'h68, 32'h0000_5000, 32'h0000_00D0, 3'd3);
        // R7 IRQ only, masked: nothing taken.
        step(7'h20, 32'h0000_6000, 32'h0000_0090, 3'd1);
        // R3 link wraps; R6 bit6 kept clear for software interrupt.
        step(7'h04, 32'hFFFF_FFFC, 32'h8000_0010, 3'd2);
        // R9 read back svc bank after overwrite; R9 out-of-range indices.
        step(7'h00, 32'h0, 32'h10, 3'd2);
        step(7'h00, 32'h0, 32'h10, 3'd5);
        step(7'h00, 32'h0, 32'h10, 3'd7);
        // FIQ accepted, data abort alone.
        step(7'h40, 32'h0000_7000, 32'h0000_0012, 3'd0);
        step(7'h10, 32'h0000_8000, 32'h0000_0040, 3'd0);
        // Random mix.
        for (int n = 0; n < 600; n++) begin
            step(7'($urandom & $urandom & $urandom), $urandom, $urandom, 3'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule